// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block follows the load-linked reservations held by one requester on cache lines. It watches the completion events that come back from the memory system, each tagged with a line address and an operation code, and it returns the result of every store-conditional: it succeeds only when the line is still reserved by this requester. It also drops reservations when plain stores complete or when a coherence invalidate arrives. Locked read-modify-write pairs are turned into block and unblock commands for their line.

Reservations sit in a small table of valid bits and line addresses. A load-linked to a line that is not yet reserved takes a free entry. When the table is full, it takes the entry that was reserved longest ago. A test-mode input switches the reservation logic off, and every write completion then reports success. Each completion is answered by one registered response one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: Every cycle with `cmp_valid` high yields exactly one `rsp_valid` pulse on the next cycle. When `rsp_valid` is low, `rsp_ok` and `rsp_sc_val` are low as well.
- R2: A load-linked completion (op code 2) reserves its line and answers `rsp_ok`=1 with `rsp_sc_val`=0.
- R3: A store-conditional completion (op code 3) answers `rsp_ok`=1 and `rsp_sc_val`=1 when its line is reserved, and `rsp_ok`=0 and `rsp_sc_val`=0 when it is not.
- R4: A store-conditional always removes the reservation on its line, so a second store-conditional to that line fails.
- R5: A plain write completion (op code 1) with `cmp_present`=1 removes the reservation on its line. With `cmp_present`=0 the reservation stays.
- R6: Read completions (op code 0, and the unused codes 6 and 7) answer `rsp_ok`=1 and `rsp_sc_val`=0 and leave every reservation as it was.
- R7: A locked-read completion (op code 4) gives a one-cycle `blk_valid` pulse carrying its line on `blk_line`. A locked-write completion (op code 5) gives the same kind of pulse on `unblk_valid`/`unblk_line`. The two never pulse together.
- R8: While `bypass` is high, every completion answers `rsp_ok`=1, a store-conditional answers `rsp_sc_val`=1, and no reservation is added or removed by that completion.
- R9: The table holds `ENTRIES` reservations. A load-linked to a line that is already reserved takes no new entry and does not change the age order. A load-linked arriving when the table is full evicts the oldest reservation.
- R10: An `inv_valid` pulse removes any reservation on `inv_line`, whether or not a completion arrives in the same cycle.
- R11: When an invalidate and a store-conditional name the same line in the same cycle, the store-conditional fails. When a load-linked and an invalidate name the same line in the same cycle, the line ends up reserved.
- R12: After reset there are no reservations and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | A completion event is present |
| cmp_op | input | 3 | Operation code of the completion |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_present | input | 1 | The line is present in the cache (used by plain writes) |
| bypass | input | 1 | Test mode: reservation checking switched off |
| inv_valid | input | 1 | Coherence invalidate pulse |
| inv_line | input | LINE_W | Line address being invalidated |
| rsp_valid | output | 1 | Response for the previous cycle's completion |
| rsp_ok | output | 1 | Completion succeeded |
| rsp_sc_val | output | 1 | Store-conditional result value |
| blk_valid | output | 1 | Block command pulse |
| blk_line | output | LINE_W | Line to block |
| unblk_valid | output | 1 | Unblock command pulse |
| unblk_line | output | LINE_W | Line to unblock |

## Verification
Every output, whether the response flags or the block and unblock pulses, is due exactly one clock after the completion or invalidate that causes it. Reservation changes take effect for a completion in the following cycle. The bench drives inputs on the falling edge and checks all outputs on the next falling edge against a queue-based model that was stepped when those inputs were applied. Every cycle is therefore compared with no slack. A store-conditional issued right after a load-linked, a plain write or an invalidate tests the one-cycle visibility of the table update.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  // Completion operation codes; codes 6 and 7 behave as reads.
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_LKRD  = 3'd4,
    OP_LKWR  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  // Decoded actions for one completion.
  typedef struct packed {
    logic ll_set;   // reserve the line (checking enabled)
    logic sc_chk;   // check and clear (checking enabled)
    logic wr_clr;   // plain write may clear (checking enabled)
    logic sc_any;   // any store-conditional, bypass or not
    logic lk_rd;    // locked read: block line
    logic lk_wr;    // locked write: unblock line
  } op_dec_t;

endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
  import llsc_pkg::*;
(
  input  logic       cmp_valid,
  input  logic [2:0] cmp_op,
  input  logic       bypass,
  output op_dec_t    dec
);

  op_e op;
  logic chk_en;

  always_comb begin
    op     = op_e'(cmp_op);
    chk_en = cmp_valid & ~bypass;
    dec    = '0;
    unique case (op)
      OP_LL:    dec.ll_set = chk_en;
      OP_SC: begin
        dec.sc_chk = chk_en;
        dec.sc_any = cmp_valid;
      end
      OP_WRITE: dec.wr_clr = chk_en;
      OP_LKRD:  dec.lk_rd  = cmp_valid;
      OP_LKWR:  dec.lk_wr  = cmp_valid;
      default:  dec        = '0;
    endcase
  end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_set,
  input  logic              sc_chk,
  input  logic              wr_clr,
  input  logic              present,
  input  logic [LINE_W-1:0] line,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              sc_hit
);

  localparam int RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int IDX_W  = RANK_W;
  localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(ENTRIES - 1);

  // State
  logic [ENTRIES-1:0]             valid_q;
  logic [LINE_W-1:0]              line_q [ENTRIES];
  logic [RANK_W-1:0]              rank_q [ENTRIES];

  // Next state
  logic [ENTRIES-1:0]             valid_d;
  logic [RANK_W-1:0]              rank_d [ENTRIES];
  logic [ENTRIES-1:0]             load_en;

  // Intermediate
  logic [ENTRIES-1:0]             match_cmp;
  logic [ENTRIES-1:0]             match_inv;
  logic [ENTRIES-1:0]             free;
  logic [ENTRIES-1:0]             valid_pf;
  logic [RANK_W-1:0]              rank_pf [ENTRIES];
  logic [ENTRIES-1:0]             held;
  logic                           need_alloc;
  logic                           any_free;
  logic [IDX_W-1:0]               free_idx;
  logic [IDX_W-1:0]               victim_idx;
  logic [IDX_W-1:0]               alloc_idx;

  // Per-entry match and free
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match_cmp[g] = valid_q[g] && (line_q[g] == line);
    assign match_inv[g] = inv_valid && valid_q[g] && (line_q[g] == inv_line);
    assign free[g]      = match_inv[g] |
                          (match_cmp[g] & (sc_chk | (wr_clr & present)));
    assign valid_pf[g]  = valid_q[g] & ~free[g];
    assign held[g]      = valid_pf[g] && (line_q[g] == line);
  end

  // Invalidate wins over a store-conditional on the same line.
  assign sc_hit = sc_chk && |(match_cmp & ~match_inv);

  // Age ranks after removals: close gaps left by freed entries.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [RANK_W-1:0] dec_cnt;
      dec_cnt = '0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (free[j] && (rank_q[j] < rank_q[i])) dec_cnt = dec_cnt + RANK_W'(1);
      end
      rank_pf[i] = valid_pf[i] ? (rank_q[i] - dec_cnt) : '0;
    end
  end

  // Slot selection
  always_comb begin
    any_free   = 1'b0;
    free_idx   = '0;
    victim_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_pf[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (valid_pf[i] && (rank_pf[i] == RANK_MAX)) victim_idx = IDX_W'(i);
    end
    alloc_idx  = any_free ? free_idx : victim_idx;
    need_alloc = ll_set && !(|held);
  end

  // Next-state
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      load_en[i] = 1'b0;
      valid_d[i] = valid_pf[i];
      rank_d[i]  = rank_pf[i];
      if (need_alloc) begin
        if (alloc_idx == IDX_W'(i)) begin
          load_en[i] = 1'b1;
          valid_d[i] = 1'b1;
          rank_d[i]  = '0;
        end else if (valid_pf[i]) begin
          rank_d[i]  = rank_pf[i] + RANK_W'(1);
        end
      end
    end
  end

  // Registers
  for (genvar g = 0; g < ENTRIES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        rank_q[g]  <= '0;
      end else begin
        valid_q[g] <= valid_d[g];
        rank_q[g]  <= rank_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (load_en[g]) line_q[g] <= line;
    end
  end

endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              sc_any,
  input  logic              bypass,
  input  logic              sc_hit,
  input  logic              lk_rd,
  input  logic              lk_wr,
  input  logic [LINE_W-1:0] line,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_sc_val,
  output logic              blk_valid,
  output logic [LINE_W-1:0] blk_line,
  output logic              unblk_valid,
  output logic [LINE_W-1:0] unblk_line
);

  logic ok_d;
  logic val_d;

  always_comb begin
    ok_d  = cmp_valid & ~(sc_any & ~bypass & ~sc_hit);
    val_d = sc_any & (bypass | sc_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_sc_val  <= 1'b0;
      blk_valid   <= 1'b0;
      unblk_valid <= 1'b0;
      blk_line    <= '0;
      unblk_line  <= '0;
    end else begin
      rsp_valid   <= cmp_valid;
      rsp_ok      <= ok_d;
      rsp_sc_val  <= val_d;
      blk_valid   <= lk_rd;
      unblk_valid <= lk_wr;
      if (lk_rd) blk_line   <= line;
      if (lk_wr) unblk_line <= line;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_op,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              cmp_present,
  input  logic              bypass,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_sc_val,
  output logic              blk_valid,
  output logic [LINE_W-1:0] blk_line,
  output logic              unblk_valid,
  output logic [LINE_W-1:0] unblk_line
);

  op_dec_t dec;
  logic    sc_hit;

  llsc_decode u_dec (
    .cmp_valid (cmp_valid),
    .cmp_op    (cmp_op),
    .bypass    (bypass),
    .dec       (dec)
  );

  llsc_resv_table #(
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ll_set    (dec.ll_set),
    .sc_chk    (dec.sc_chk),
    .wr_clr    (dec.wr_clr),
    .present   (cmp_present),
    .line      (cmp_line),
    .inv_valid (inv_valid),
    .inv_line  (inv_line),
    .sc_hit    (sc_hit)
  );

  llsc_resp #(
    .LINE_W (LINE_W)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid   (cmp_valid),
    .sc_any      (dec.sc_any),
    .bypass      (bypass),
    .sc_hit      (sc_hit),
    .lk_rd       (dec.lk_rd),
    .lk_wr       (dec.lk_wr),
    .line        (cmp_line),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .rsp_sc_val  (rsp_sc_val),
    .blk_valid   (blk_valid),
    .blk_line    (blk_line),
    .unblk_valid (unblk_valid),
    .unblk_line  (unblk_line)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic [2:0]        cmp_op,
  input logic [LINE_W-1:0] cmp_line,
  input logic              cmp_present,
  input logic              bypass,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_sc_val,
  input logic              blk_valid,
  input logic [LINE_W-1:0] blk_line,
  input logic              unblk_valid,
  input logic [LINE_W-1:0] unblk_line
);

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> rsp_valid);

  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_ok && !rsp_sc_val));

  // R3
  fail_only_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |->
      (!rsp_sc_val && ($past(cmp_op) == 3'd3) && !$past(bypass)));

  // R2
  ll_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid && (cmp_op == 3'd2)) |-> (rsp_ok && !rsp_sc_val));

  // R7
  blk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> ($past(cmp_valid && (cmp_op == 3'd4)) && (blk_line == $past(cmp_line))));

  // R7
  unblk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_valid |-> ($past(cmp_valid && (cmp_op == 3'd5)) && (unblk_line == $past(cmp_line))));

  // R7
  blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_valid, unblk_valid}));

  // R8
  bypass_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid && bypass) |-> rsp_ok);

  // R11
  inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid && (cmp_op == 3'd3) && !bypass && inv_valid && (inv_line == cmp_line))
      |-> (rsp_valid && !rsp_ok));

endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 4;
  localparam int LINE_W     = 26;

  logic              clk;
  logic              rst_n;
  logic              cmp_valid;
  logic [2:0]        cmp_op;
  logic [LINE_W-1:0] cmp_line;
  logic              cmp_present;
  logic              bypass;
  logic              inv_valid;
  logic [LINE_W-1:0] inv_line;
  logic              rsp_valid, rsp_ok, rsp_sc_val;
  logic              blk_valid, unblk_valid;
  logic [LINE_W-1:0] blk_line, unblk_line;

  llsc_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Model state: reserved lines, oldest at the front.
  logic [LINE_W-1:0] resv[$];
  logic exp_valid, exp_ok, exp_val, exp_blk, exp_unblk;
  logic [LINE_W-1:0] exp_line;
  string exp_tag;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic int find_line(input logic [LINE_W-1:0] ln);
    foreach (resv[k]) if (resv[k] == ln) return k;
    return -1;
  endfunction

  task automatic check_now();
    logic [6:0] act, exp;
    act = {rsp_valid, rsp_ok, rsp_sc_val, blk_valid, unblk_valid, 2'b00};
    exp = {exp_valid, exp_ok, exp_val, exp_blk, exp_unblk, 2'b00};
    n_checks++;
    if (act !== exp ||
        (exp_blk && blk_line !== exp_line) ||
        (exp_unblk && unblk_line !== exp_line)) begin
      n_fail++;
      $display("FAIL %s: actual v/ok/val/blk/unblk=%b blk_line=%0d unblk_line=%0d expected=%b line=%0d",
               exp_tag, act[6:2], blk_line, unblk_line, exp[6:2], exp_line);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input int ln,
                      input logic pres, input logic byp,
                      input logic iv, input int il, input string tag);
    int k;
    logic hit;
    @(negedge clk);
    check_now();
    cmp_valid = v; cmp_op = op; cmp_line = LINE_W'(ln); cmp_present = pres;
    bypass = byp; inv_valid = iv; inv_line = LINE_W'(il);
    // invalidate is applied first
    if (iv) begin
      k = find_line(LINE_W'(il));
      if (k >= 0) resv.delete(k);
    end
    hit = 1'b0;
    if (v && !byp) begin
      k = find_line(LINE_W'(ln));
      case (op)
        3'd2: if (k < 0) begin
          if (resv.size() == ENTRIES) void'(resv.pop_front());
          resv.push_back(LINE_W'(ln));
        end
        3'd3: begin
          hit = (k >= 0);
          if (k >= 0) resv.delete(k);
        end
        3'd1: if (pres && k >= 0) resv.delete(k);
        default: ;
      endcase
    end
    exp_valid = v;
    exp_ok    = v && !(op == 3'd3 && !byp && !hit);
    exp_val   = v && op == 3'd3 && (byp || hit);
    exp_blk   = v && op == 3'd4;
    exp_unblk = v && op == 3'd5;
    exp_line  = LINE_W'(ln);
    exp_tag   = tag;
  endtask

  task automatic op1(input logic [2:0] op, input int ln, input string tag);
    step(1'b1, op, ln, 1'b1, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    cmp_valid = 0; cmp_op = 0; cmp_line = 0; cmp_present = 0;
    bypass = 0; inv_valid = 0; inv_line = 0;
    exp_valid = 0; exp_ok = 0; exp_val = 0; exp_blk = 0; exp_unblk = 0;
    exp_line = 0; exp_tag = "R12 reset";
    repeat (3) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R12 idle");
    // R12: no reservation after reset, R6 read, R3 failing SC
    op1(3'd3, 5, "R12 sc after reset");
    op1(3'd0, 5, "R6 read");
    op1(3'd3, 5, "R3 sc unreserved");
    // R2 / R3 / R4
    op1(3'd2, 5, "R2 ll");
    op1(3'd3, 5, "R3 sc reserved");
    op1(3'd3, 5, "R4 sc after sc");
    // R5 / R6
    op1(3'd2, 7, "R2 ll");
    step(1, 3'd1, 7, 1'b0, 0, 0, 0, "R5 write absent");
    op1(3'd0, 7, "R6 read");
    op1(3'd6, 7, "R6 code6");
    op1(3'd3, 7, "R5 sc kept");
    op1(3'd2, 7, "R2 ll");
    op1(3'd1, 7, "R5 write present");
    op1(3'd3, 7, "R5 sc cleared");
    // R7
    op1(3'd4, 9, "R7 block");
    op1(3'd5, 9, "R7 unblock");
    op1(3'd4, 13, "R7 block");
    step(0, 0, 0, 0, 0, 0, 0, "R7 idle");
    // R8
    step(1, 3'd2, 11, 1, 1, 0, 0, "R8 ll bypass");
    step(1, 3'd3, 11, 1, 1, 0, 0, "R8 sc bypass");
    op1(3'd3, 11, "R8 sc no reservation");
    op1(3'd2, 12, "R2 ll");
    step(1, 3'd3, 12, 1, 1, 0, 0, "R8 sc bypass keeps");
    step(1, 3'd1, 12, 1, 1, 0, 0, "R8 write bypass keeps");
    op1(3'd3, 12, "R8 reservation intact");
    // R9 capacity and oldest eviction
    op1(3'd2, 1, "R9 fill");
    op1(3'd2, 2, "R9 fill");
    op1(3'd2, 3, "R9 fill");
    op1(3'd2, 4, "R9 fill");
    op1(3'd2, 2, "R9 repeat ll");
    op1(3'd2, 6, "R9 evict");
    op1(3'd3, 1, "R9 oldest gone");
    op1(3'd3, 2, "R9 kept");
    op1(3'd3, 3, "R9 kept");
    op1(3'd3, 4, "R9 kept");
    op1(3'd3, 6, "R9 kept");
    op1(3'd2, 1, "R9 reuse");
    op1(3'd2, 2, "R9 reuse");
    op1(3'd2, 3, "R9 reuse");
    op1(3'd3, 2, "R9 free middle");
    op1(3'd2, 4, "R9 reuse");
    op1(3'd2, 5, "R9 reuse");
    op1(3'd2, 6, "R9 evict after gap");
    op1(3'd3, 1, "R9 oldest gone");
    op1(3'd3, 3, "R9 kept");
    // R10
    op1(3'd2, 20, "R2 ll");
    step(0, 0, 0, 0, 0, 1, 20, "R10 invalidate");
    op1(3'd3, 20, "R10 sc after inv");
    op1(3'd2, 21, "R2 ll");
    step(1, 3'd0, 21, 1, 0, 1, 22, "R10 other inv");
    op1(3'd3, 21, "R10 untouched");
    // R11
    op1(3'd2, 30, "R2 ll");
    step(1, 3'd3, 30, 1, 0, 1, 30, "R11 inv and sc");
    op1(3'd2, 31, "R2 ll");
    step(1, 3'd3, 31, 1, 0, 1, 32, "R11 inv other line");
    step(1, 3'd2, 33, 1, 0, 1, 33, "R11 ll with inv");
    op1(3'd3, 33, "R11 ll wins");
    // R1 mixed traffic
    for (int n = 0; n < 600; n++) begin
      step(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
           $urandom_range(0, 7), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 5) == 0),
           $urandom_range(0, 7), "R1 mixed");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R1 drain");
    @(negedge clk);
    check_now();
    done = 1;
    finish_run();
  end

endmodule